// File: doc/BRIEF.md
# Autocorrelation Loop-Gain Optimizer

This block calibrates, in the background, the proportional-path gain of a digital phase-locked loop. Once per reference cycle it takes the one-bit decision of the loop's centre comparator, an encoding of +1 or -1. It compares that decision with the one from the previous reference cycle and nudges a saturating accumulator. If the two decisions agree (positive lag-one correlation), the loop gain is too low and the accumulator rises. If they alternate (negative correlation), the gain is too high and it falls. The loop settles where the decision stream has zero lag-one autocorrelation. This is a sign-sign LMS update.

The upper bits of the accumulator form the gain code that sets the proportional gain. The fractional bits below the code set the adaptation step. The code moves by one only after a net 2^STEP_SHIFT steps in one direction. Adaptation runs only on reference-rate enable pulses and only while the adaptation enable is high.

Top module: `loop_gain_optimizer`

## Requirements
- R1: In a cycle with reset low at the clock edge, the gain code becomes INIT_CODE (default 4096) and the stored previous decision is cleared.
- R2: The first reference tick after reset only stores the decision; the accumulator does not change on that tick.
- R3: The decision input `dm_sign` encodes 1 as +1 and 0 as -1. On an active tick where `dm_sign` equals the stored previous decision, the internal accumulator (CODE_W+STEP_SHIFT bits) rises by one.
- R4: On an active tick where `dm_sign` differs from the stored previous decision, the accumulator falls by one.
- R5: The gain code is the accumulator shifted right by STEP_SHIFT (default 3). The accumulator saturates at all ones, so the code holds at 8191 and never wraps to zero.
- R6: At zero, the accumulator saturates; the code holds at 0 and never wraps to the maximum.
- R7: With `ref_tick` low, neither the accumulator nor the stored decision changes, whatever `dm_sign` does.
- R8: With `adapt_en` low, the accumulator is frozen, but ticks still store the decision. The first active tick after re-enabling compares against the decision stored while frozen.
- R9: With default parameters, a full-scale sweep from the top of the code range to code 0 takes no more than 75000 ticks (750 us at a 100 MHz update rate).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_tick | input | 1 | One-cycle enable at the reference rate |
| dm_sign | input | 1 | Centre comparator decision: 1 = +1, 0 = -1 |
| adapt_en | input | 1 | Adaptation enable; low freezes the gain |
| gain_code | output | CODE_W (13) | Proportional-path gain code |

## Verification
Within a single tick, the block may have to store the new decision and also apply the comparison against the old one. Frozen ticks store the decision without adapting. Saturation at either limit coincides with a step that would otherwise wrap.

These collisions are provoked in two ways. Directed sequences toggle `adapt_en` between ticks and drive long agreeing or alternating runs into the limits. Seeded random runs mix tick gaps, decisions and enable changes.

Every tick is judged against a bench model of the accumulator. Single steps become visible at the code output because the reset value sits exactly on a code boundary.

// File: rtl/lgo_pkg.sv
// Shared types for the loop-gain optimizer.
// Assumes nothing beyond a single clock domain.
package lgo_pkg;
    // Direction the accumulator moves on a given cycle.
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_dir_e;
endpackage

// File: rtl/lgo_lag_corr.sv
// Lag-one correlation sign of the centre comparator decision.
// Stores the decision of the previous tick and, on each tick after the
// first since reset, reports whether the new decision agrees (UP) or
// differs (DOWN). Assumes tick is a single-cycle pulse.
module lgo_lag_corr
    import lgo_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      dm,
    output step_dir_e dir
);
    logic dm_prev;
    logic hist_valid;

    // Record the decision and mark history valid on every tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dm_prev    <= 1'b0;
            hist_valid <= 1'b0;
        end else if (tick) begin
            dm_prev    <= dm;
            hist_valid <= 1'b1;
        end
    end

    // Sign of the product dm * dm_prev, only when history exists.
    always_comb begin
        dir = STEP_NONE;
        if (tick && hist_valid) begin
            dir = (dm == dm_prev) ? STEP_UP : STEP_DOWN;
        end
    end

    // R2: first tick after reset yields no step
    p_first_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !hist_valid) |-> (dir == STEP_NONE));

    // R7: history holds without a tick
    p_hist_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(dm_prev) && $stable(hist_valid)));
endmodule

// File: rtl/lgo_sat_acc.sv
// Saturating up/down accumulator holding the gain with fractional bits.
// Moves by one LSB per requested step and clamps at zero and all ones.
// Assumes dir is STEP_NONE whenever no update is wanted.
module lgo_sat_acc
    import lgo_pkg::*;
#(
    parameter int ACC_W = 16,
    parameter logic [ACC_W-1:0] INIT_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_dir_e        dir,
    output logic [ACC_W-1:0] acc_q
);
    localparam logic [ACC_W-1:0] ACC_MAX = '1;
    localparam logic [ACC_W-1:0] ACC_ONE = ACC_W'(1);

    // Step up or down by one, clamping at the range ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= INIT_VAL;
        end else begin
            case (dir)
                STEP_UP:   if (acc_q != ACC_MAX) acc_q <= acc_q + ACC_ONE;
                STEP_DOWN: if (acc_q != '0)      acc_q <= acc_q - ACC_ONE;
                default:   acc_q <= acc_q;
            endcase
        end
    end

    // R3: agreeing step below the top raises by one
    p_step_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == STEP_UP && acc_q != ACC_MAX) |=> (acc_q == $past(acc_q) + ACC_ONE));

    // R4: differing step above zero lowers by one
    p_step_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == STEP_DOWN && acc_q != '0) |=> (acc_q == $past(acc_q) - ACC_ONE));

    // R5: no wrap past the top
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == STEP_UP && acc_q == ACC_MAX) |=> (acc_q == ACC_MAX));

    // R6: no wrap below zero
    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == STEP_DOWN && acc_q == '0) |=> (acc_q == '0));
endmodule

// File: rtl/loop_gain_optimizer.sv
// Background loop-gain optimizer: drives the proportional-gain code so the
// centre comparator decision has zero lag-one autocorrelation.
// Assumes ref_tick pulses for one cycle per reference period and that
// dm_sign is valid whenever ref_tick is high.
module loop_gain_optimizer
    import lgo_pkg::*;
#(
    parameter int CODE_W     = 13,
    parameter int STEP_SHIFT = 3,
    parameter int INIT_CODE  = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_tick,
    input  logic              dm_sign,
    input  logic              adapt_en,
    output logic [CODE_W-1:0] gain_code
);
    localparam int ACC_W = CODE_W + STEP_SHIFT;
    localparam logic [ACC_W-1:0] INIT_ACC = ACC_W'(INIT_CODE) << STEP_SHIFT;

    step_dir_e        corr_dir;
    step_dir_e        acc_dir;
    logic [ACC_W-1:0] acc;

    lgo_lag_corr u_corr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick),
        .dm    (dm_sign),
        .dir   (corr_dir)
    );

    // Gate adaptation with the enable; history keeps tracking regardless.
    always_comb begin
        acc_dir = adapt_en ? corr_dir : STEP_NONE;
    end

    lgo_sat_acc #(
        .ACC_W    (ACC_W),
        .INIT_VAL (INIT_ACC)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .dir   (acc_dir),
        .acc_q (acc)
    );

    // Code is the integer part of the accumulator.
    always_comb begin
        gain_code = acc[ACC_W-1 -: CODE_W];
    end

    // R8: frozen while adaptation is disabled
    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !adapt_en |=> $stable(gain_code));

    // R7: no change without a reference tick
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ref_tick |=> $stable(gain_code));

    // R1: reset loads the initial code
    p_reset_init_r1: assert property (@(posedge clk)
        !rst_n |=> (gain_code == CODE_W'(INIT_CODE)));
endmodule

// File: tb/loop_gain_optimizer_bench.sv
module loop_gain_optimizer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int CODE_W     = 13;
    localparam int STEP_SHIFT = 3;
    localparam int INIT_CODE  = 4096;
    localparam int ACC_MAX    = (1 << (CODE_W + STEP_SHIFT)) - 1;
    localparam int SETTLE_MAX = 75000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_tick = 1'b0;
    logic dm_sign = 1'b0;
    logic adapt_en = 1'b0;
    logic [CODE_W-1:0] gain_code;

    int n_checks = 0;
    int n_fails  = 0;
    int m_acc;
    bit m_prev;
    bit m_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    loop_gain_optimizer #(
        .CODE_W(CODE_W), .STEP_SHIFT(STEP_SHIFT), .INIT_CODE(INIT_CODE)
    ) u_loop_gain_optimizer (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
        .dm_sign(dm_sign), .adapt_en(adapt_en), .gain_code(gain_code)
    );

    function automatic int exp_code();
        return m_acc >> STEP_SHIFT;
    endfunction

    task automatic check(input int act, input int exp, input string tag);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: gain_code actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Model of one clock edge with the given inputs.
    task automatic step(input bit tk, input bit d, input bit en, input string tag);
        @(negedge clk);
        ref_tick = tk; dm_sign = d; adapt_en = en;
        @(posedge clk);
        if (tk) begin
            if (m_valid && en) begin
                if (d == m_prev) m_acc = (m_acc < ACC_MAX) ? m_acc + 1 : ACC_MAX;
                else             m_acc = (m_acc > 0) ? m_acc - 1 : 0;
            end
            m_valid = 1'b1;
            m_prev  = d;
        end
        #(CLK_PERIOD/4);
        check(int'(gain_code), exp_code(), tag);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; ref_tick = 1'b1; dm_sign = 1'b1; adapt_en = 1'b1;
        @(posedge clk);
        @(posedge clk);
        m_acc = INIT_CODE << STEP_SHIFT; m_valid = 1'b0; m_prev = 1'b0;
        #(CLK_PERIOD/4);
        check(int'(gain_code), INIT_CODE, "R1");
        @(negedge clk);
        rst_n = 1'b1; ref_tick = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 190000);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        int cnt;
        void'($urandom(32'd20240611));
        do_reset();
        // R2: first tick differs from cleared history but must not step down.
        step(1'b1, 1'b1, 1'b1, "R2");
        check(int'(gain_code), INIT_CODE, "R2");
        // R4: differing decision from the code boundary is visible.
        step(1'b1, 1'b0, 1'b1, "R4");
        check(int'(gain_code), INIT_CODE - 1, "R4");
        // R3: eight agreements climb past the boundary.
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b1, "R3");
        check(int'(gain_code), INIT_CODE, "R3");
        // R7: no tick, decisions toggle, nothing moves.
        for (int i = 0; i < 6; i++) step(1'b0, i[0], 1'b1, "R7");
        // R8: frozen ticks store history; next active tick agrees with it.
        do_reset();
        step(1'b1, 1'b0, 1'b1, "R8");
        step(1'b1, 1'b1, 1'b0, "R8");
        check(int'(gain_code), INIT_CODE, "R8");
        step(1'b1, 1'b1, 1'b1, "R8");
        check(int'(gain_code), INIT_CODE, "R8");
        step(1'b1, 1'b0, 1'b0, "R8");
        step(1'b1, 1'b1, 1'b1, "R8");
        check(int'(gain_code), INIT_CODE, "R8");
        // Random mix of gaps, decisions and enables.
        do_reset();
        for (int i = 0; i < 3000; i++)
            step(($urandom % 4) != 0, $urandom % 2, ($urandom % 8) != 0, "R3/R4 random");
        // R5: long agreeing run into the ceiling.
        for (int i = 0; i < 66000 && m_acc < ACC_MAX; i++) step(1'b1, 1'b1, 1'b1, "R5");
        for (int i = 0; i < 20; i++) step(1'b1, 1'b1, 1'b1, "R5");
        check(int'(gain_code), (1 << CODE_W) - 1, "R5");
        // R9: alternating run from the top down to code zero.
        cnt = 0;
        while (gain_code != 0 && cnt < SETTLE_MAX + 10) begin
            step(1'b1, cnt[0], 1'b1, "R9");
            cnt++;
        end
        check((cnt <= SETTLE_MAX) ? 1 : 0, 1, "R9");
        // R6: keep alternating into the floor.
        for (int i = 0; i < 40; i++) step(1'b1, i[0] ^ cnt[0], 1'b1, "R6");
        check(int'(gain_code), 0, "R6");
        // R6: agreeing step after floor climbs normally (no wrap to top).
        step(1'b1, dm_sign, 1'b1, "R6");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule